// File: doc/BRIEF.md
# Memory-Mapped Hardware Message Queue

This block lets processors pass fixed-size messages to each other through a set of hardware queues. Each message is 64 bytes, held as sixteen 32-bit words. Every queue has its own address window of data registers. A producer fills the window and commits the message by writing the last register. A consumer reads the window and removes the head message by reading the last register. Each queue also has a status word that reports how many messages are pending and whether a commit was ever lost. A receive interrupt line stays high while the queue holds a message.

Access goes through a 32-bit register port with a request valid/ready pair and a registered read response. Only full, word-aligned 32-bit accesses are decoded. Each queue has a staging buffer for writes, so the non-final words of a message may arrive in any order. Short messages leave zeros in the words they did not write. The number of queues and the depth of each queue are parameters.

Top module: `msgq_top`

## Requirements
- R1: While reset is asserted and right after it, every interrupt line is low, no read response is valid, and every status word reads zero.
- R2: Address map. Bit 20 of the byte address selects the region: 0 for data, 1 for status. A data register sits at 0x10000*proxy + 0x80*queue + 4*index, with indices 16 to 31 forming one message (index 16 is word 0). The status word of queue q sits at 0x100000 + 4*q. It holds the pending count in bits 23:12 and the sticky overflow flag in bit 0, with all other bits zero. Writes to the status region have no effect.
- R3: A write to index 31 commits the staged words 0..14, together with the written value as word 15, at the tail of the queue. The count rises by one after that clock edge.
- R4: Every accepted read returns its data with a valid pulse one cycle later. Reading indices 16..30 returns the matching word of the head message and does not change the count.
- R5: A read of index 31 returns word 15 of the head message and removes that message, so the count falls by one.
- R6: Messages leave a queue in the order they were committed, with all sixteen words intact.
- R7: A queue's interrupt line is high exactly while its count is non-zero. It changes in the same cycle as the count.
- R8: A commit to a queue that already holds DEPTH messages is dropped. The count and the stored messages stay unchanged, and overflow bit 0 of the status word is set and stays set until reset.
- R9: Reading any data register of an empty queue returns zero and changes nothing.
- R10: Every commit, whether kept or dropped, clears that queue's staging buffer. A message that writes only some of words 0..14 carries zeros in the others.
- R11: The following accesses return zero and have no effect: a nonzero proxy field, a queue number at or above NQ, an index below 16, an unaligned address, or a status offset for a queue at or above NQ.
- R12: Accesses to one queue never change the count, contents or staging of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access request |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 21 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Request accepted (always ready) |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | NQ | Per-queue receive interrupt |

## Verification
A wrong head or tail pointer shows up on the first read of a later message, as a word from the wrong slot. A wrong count shows up within one cycle on the interrupt line, and in the next status read. Staging that is not cleared is exposed by reading back a short message, where stale words replace the zeros. The reference model checks every interrupt line on every clock and every read value on the cycle it returns, so a corrupted state is caught at its first visible effect.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int ADDR_W    = 21;
  localparam int REGION_B  = 20;
  localparam int PROXY_LSB = 16;
  localparam int PROXY_W   = 4;
  localparam int QF_LSB    = 7;
  localparam int QF_W      = 9;
  localparam int IDX_LSB   = 2;
  localparam int IDX_W     = 5;
  localparam int MSG_WORDS = 16;
  localparam int WIDX_W    = 4;
  localparam int STQ_W     = 18;
  localparam int CNT_LSB   = 12;
  localparam int CNT_FW    = 12;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
  import msgq_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int QI_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [QI_W-1:0]   q_o,
  output logic [WIDX_W-1:0] widx_o
);
  logic [PROXY_W-1:0] proxy;
  logic [QF_W-1:0]    qf;
  logic [IDX_W-1:0]   idx;
  logic [STQ_W-1:0]   stq;
  logic               aligned, data_ok, stat_ok;

  assign proxy   = addr_i[PROXY_LSB +: PROXY_W];
  assign qf      = addr_i[QF_LSB +: QF_W];
  assign idx     = addr_i[IDX_LSB +: IDX_W];
  assign stq     = addr_i[IDX_LSB +: STQ_W];
  assign aligned = addr_i[1:0] == 2'b00;

  // index must lie in the message window (16..31)
  assign data_ok = !addr_i[REGION_B] && aligned && (proxy == '0)
                   && (int'(qf) < NQ) && idx[IDX_W-1];
  assign stat_ok = addr_i[REGION_B] && aligned && (int'(stq) < NQ);

  always_comb begin
    kind_o = ACC_NONE;
    if (data_ok)      kind_o = ACC_DATA;
    else if (stat_ok) kind_o = ACC_STAT;
  end

  assign q_o    = addr_i[REGION_B] ? stq[QI_W-1:0] : qf[QI_W-1:0];
  assign widx_o = idx[WIDX_W-1:0];
endmodule

// File: rtl/msgq_queue.sv
module msgq_queue
  import msgq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       head_word_o,
  output logic [CW-1:0]     count_o,
  output logic              ovf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(MSG_WORDS - 1);

  logic [31:0]   stage_q [MSG_WORDS];
  logic [31:0]   mem_q   [DEPTH][MSG_WORDS];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          commit, pop, full, empty, keep;

  function automatic logic [PW-1:0] ptr_nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = cnt_q == CW'(DEPTH);
  assign empty  = cnt_q == '0;
  assign commit = wr_i && (widx_i == LAST_W);
  assign keep   = commit && !full;
  assign pop    = rd_i && (widx_i == LAST_W) && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < MSG_WORDS; w++) stage_q[w] <= '0;
    end else if (commit) begin
      for (int w = 0; w < MSG_WORDS; w++) stage_q[w] <= '0;
    end else if (wr_i) begin
      stage_q[widx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (keep) begin
      for (int w = 0; w < MSG_WORDS - 1; w++) mem_q[wr_ptr_q][w] <= stage_q[w];
      mem_q[wr_ptr_q][MSG_WORDS-1] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (keep) begin
        wr_ptr_q <= ptr_nxt(wr_ptr_q);
        cnt_q    <= cnt_q + 1'b1;
      end else if (pop) begin
        rd_ptr_q <= ptr_nxt(rd_ptr_q);
        cnt_q    <= cnt_q - 1'b1;
      end
      if (commit && full) ovf_q <= 1'b1;
    end
  end

  assign head_word_o = empty ? '0 : mem_q[rd_ptr_q][widx_i];
  assign count_o     = cnt_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/msgq_top.sv
module msgq_top
  import msgq_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [20:0]       bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_ready_o,
  output logic              bus_rvalid_o,
  output logic [31:0]       bus_rdata_o,
  output logic [NQ-1:0]     irq_o
);
  localparam int QI_W = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int CW   = $clog2(DEPTH + 1);

  acc_kind_e               kind;
  logic [QI_W-1:0]         dq;
  logic [WIDX_W-1:0]       widx;
  logic [NQ-1:0][CW-1:0]   cnt_all;
  logic [NQ-1:0]           ovf_all;
  logic [NQ-1:0][31:0]     head_all;
  logic                    rd_acc, wr_acc;
  logic [31:0]             rd_word;
  logic                    rvalid_q;
  logic [31:0]             rdata_q;

  assign rd_acc = bus_valid_i && !bus_write_i;
  assign wr_acc = bus_valid_i && bus_write_i;

  msgq_decode #(.NQ(NQ), .QI_W(QI_W)) u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .q_o    (dq),
    .widx_o (widx)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic sel;
    assign sel = (kind == ACC_DATA) && (dq == QI_W'(i));
    msgq_queue #(.DEPTH(DEPTH), .CW(CW)) u_q (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_acc && sel),
      .rd_i        (rd_acc && sel),
      .widx_i      (widx),
      .wdata_i     (bus_wdata_i),
      .head_word_o (head_all[i]),
      .count_o     (cnt_all[i]),
      .ovf_o       (ovf_all[i])
    );
    assign irq_o[i] = cnt_all[i] != '0;
  end

  always_comb begin
    rd_word = '0;
    case (kind)
      ACC_DATA: rd_word = head_all[dq];
      ACC_STAT: begin
        rd_word[CNT_LSB +: CNT_FW] = CNT_FW'(cnt_all[dq]);
        rd_word[0]                 = ovf_all[dq];
      end
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_word;
    end
  end

  assign bus_ready_o  = 1'b1;
  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;
endmodule

// File: rtl/msgq_chk.sv
module msgq_chk #(
  parameter int NQ    = 4,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_valid_i,
  input logic                  bus_write_i,
  input logic [20:0]           bus_addr_i,
  input logic                  bus_rvalid_o,
  input logic [NQ-1:0]         irq_o,
  input logic [NQ-1:0][CW-1:0] cnt_i,
  input logic [NQ-1:0]         ovf_i
);
  assert_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);
  assert_no_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    logic [20:0] last_addr;
    logic        hit_last;
    assign last_addr = {1'b0, 4'd0, 9'(q), 5'd31, 2'b00};
    assign hit_last  = bus_valid_i && (bus_addr_i == last_addr);

    assert_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_last && bus_write_i && (cnt_i[q] < CW'(DEPTH)))
      |=> (cnt_i[q] == CW'($past(cnt_i[q]) + 1'b1)));
    assert_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_last && !bus_write_i && (cnt_i[q] != '0))
      |=> (cnt_i[q] == CW'($past(cnt_i[q]) - 1'b1)));
    assert_full_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_last && bus_write_i && (cnt_i[q] == CW'(DEPTH)))
      |=> ((cnt_i[q] == CW'(DEPTH)) && ovf_i[q]));
    assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[q] |=> ovf_i[q]);
    assert_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[q] <= CW'(DEPTH));
    assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[q]) |-> $past(bus_valid_i && bus_write_i));
  end
endmodule

bind msgq_top msgq_chk #(.NQ(NQ), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .cnt_i        (cnt_all),
  .ovf_i        (ovf_all)
);

// File: tb/tb_msgq_top.sv
module tb_msgq_top;
  localparam int NQ = 4;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NQ-1:0] irq;

  always #5 clk = ~clk;

  msgq_top #(.NQ(NQ), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_ready_o(bus_ready),
    .bus_rvalid_o(bus_rvalid), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  int total = 0, bad = 0;

  // reference model
  logic [31:0] m_mem [NQ][DEPTH][16];
  logic [31:0] m_stage [NQ][16];
  int          m_head [NQ];
  int          m_cnt  [NQ];
  bit          m_ovf  [NQ];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] daddr(input int p, input int q, input int r);
    return {1'b0, 4'(p), 9'(q), 5'(r), 2'b00};
  endfunction

  function automatic logic [20:0] saddr(input int q);
    return 21'h100000 | 21'(q << 2);
  endfunction

  function automatic logic [31:0] model_access(input bit wr, input logic [20:0] a, input logic [31:0] d);
    int q, r, s;
    logic [31:0] res;
    res = '0;
    q = int'(a[15:7]); r = int'(a[6:2]); s = int'(a[19:2]);
    if (a[1:0] != 2'b00) return '0;
    if (!a[20]) begin
      if (a[19:16] != 4'd0 || q >= NQ || r < 16) return '0;
      if (wr) begin
        if (r < 31) m_stage[q][r-16] = d;
        else begin
          if (m_cnt[q] < DEPTH) begin
            for (int w = 0; w < 15; w++) m_mem[q][(m_head[q]+m_cnt[q])%DEPTH][w] = m_stage[q][w];
            m_mem[q][(m_head[q]+m_cnt[q])%DEPTH][15] = d;
            m_cnt[q]++;
          end else m_ovf[q] = 1'b1;
          for (int w = 0; w < 16; w++) m_stage[q][w] = '0;
        end
      end else if (m_cnt[q] != 0) begin
        res = m_mem[q][m_head[q]][r-16];
        if (r == 31) begin
          m_head[q] = (m_head[q] + 1) % DEPTH;
          m_cnt[q]--;
        end
      end
    end else if (!wr && s < NQ) begin
      res = {8'd0, 12'(m_cnt[q]), 11'd0, m_ovf[s]};
      res[23:12] = 12'(m_cnt[s]);
    end
    return res;
  endfunction

  task automatic check_irqs();
    for (int q = 0; q < NQ; q++)
      chk(irq[q] == (m_cnt[q] != 0), "R7 irq", 32'(irq[q]), 32'(m_cnt[q] != 0));
  endtask

  // called at a negedge; returns at the following negedge
  task automatic acc(input bit wr, input logic [20:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp;
    exp = model_access(wr, a, d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk(bus_rvalid == !wr, "R4 rvalid", 32'(bus_rvalid), 32'(!wr));
    if (!wr) chk(bus_rdata == exp, req, bus_rdata, exp);
    check_irqs();
  endtask

  task automatic send_msg(input int q, input int tag);
    for (int r = 16; r < 32; r++) acc(1'b1, daddr(0, q, r), {8'hA5, 8'(q), 8'(tag), 8'(r)}, "R3");
  endtask

  task automatic recv_msg(input int q, input string req);
    for (int r = 16; r < 32; r++) acc(1'b0, daddr(0, q, r), '0, req);
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_head[q] = 0; m_cnt[q] = 0; m_ovf[q] = 1'b0;
      for (int w = 0; w < 16; w++) m_stage[q][w] = '0;
    end
    repeat (3) @(negedge clk);
    chk(irq == '0, "R1 irq in reset", 32'(irq), 0);
    chk(bus_rvalid == 1'b0, "R1 rvalid in reset", 32'(bus_rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ready == 1'b1, "R2 ready", 32'(bus_ready), 1);
    for (int q = 0; q < NQ; q++) acc(1'b0, saddr(q), '0, "R1 status after reset");

    // R3 commit, R2 status layout
    send_msg(0, 1);
    acc(1'b0, saddr(0), '0, "R2 status count");
    // R4 peek without pop
    acc(1'b0, daddr(0, 0, 20), '0, "R4 peek");
    acc(1'b0, daddr(0, 0, 16), '0, "R4 peek");
    acc(1'b0, saddr(0), '0, "R4 count unchanged");
    // R5 pop
    acc(1'b0, daddr(0, 0, 31), '0, "R5 pop word15");
    acc(1'b0, saddr(0), '0, "R5 count after pop");

    // R6 ordering with three messages, R12 independence
    for (int m = 0; m < 3; m++) send_msg(1, m + 10);
    acc(1'b0, saddr(0), '0, "R12 q0 untouched");
    for (int m = 0; m < 3; m++) recv_msg(1, "R6 order");

    // R8 overflow
    for (int m = 0; m < DEPTH + 1; m++) send_msg(2, m + 20);
    acc(1'b0, saddr(2), '0, "R8 full count and overflow");
    for (int m = 0; m < DEPTH; m++) recv_msg(2, "R8 contents kept");
    acc(1'b0, saddr(2), '0, "R8 overflow sticky");

    // R9 empty reads
    acc(1'b0, daddr(0, 3, 16), '0, "R9 empty read");
    acc(1'b0, daddr(0, 3, 31), '0, "R9 empty pop");
    acc(1'b0, saddr(3), '0, "R9 count still zero");

    // R10 staging clear: full message then short message
    send_msg(3, 40);
    acc(1'b1, daddr(0, 3, 16), 32'h1111_2222, "R10");
    acc(1'b1, daddr(0, 3, 31), 32'h0, "R10");
    recv_msg(3, "R10 first message");
    recv_msg(3, "R10 short message zeros");

    // R11 out of window
    acc(1'b1, daddr(1, 0, 31), 32'hDEAD_BEEF, "R11");
    acc(1'b1, daddr(0, NQ, 31), 32'hDEAD_BEEF, "R11");
    acc(1'b1, daddr(0, 0, 5), 32'hDEAD_BEEF, "R11");
    acc(1'b1, saddr(0), 32'hFFFF_FFFF, "R11 status write");
    acc(1'b1, daddr(0, 0, 31) | 21'd1, 32'hDEAD_BEEF, "R11 unaligned");
    acc(1'b0, saddr(0), '0, "R11 q0 count unchanged");
    send_msg(0, 50);
    acc(1'b0, daddr(1, 0, 16), '0, "R11 proxy read zero");
    acc(1'b0, daddr(0, 0, 3), '0, "R11 low index zero");
    acc(1'b0, saddr(NQ), '0, "R11 status out of range");
    acc(1'b0, daddr(0, 0, 31) | 21'd2, '0, "R11 unaligned read");
    recv_msg(0, "R12 q0 message intact");
    repeat (2) begin
      @(negedge clk);
      chk(bus_rvalid == 1'b0, "R4 idle rvalid", 32'(bus_rvalid), 0);
      check_irqs();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule